// File: doc/BRIEF.md
# UART Channel Doze Controller

This block decides when one UART channel may drop into a low-power doze state and when it has to come back out. It watches a doze request from the host, an idle indication from the channel (FIFOs drained, nothing pending), host write activity, pending interrupts and the serial receive input. Its registered `doze` output is meant to gate the channel clock. A one-cycle `wake_evt` pulse marks every return to the awake state. It also carries a self-clearing software-reset bit that holds the channel in reset for a fixed number of reference-clock cycles.

A mode input chooses how the receive line is treated. In level mode, a low line both keeps the channel from dozing and wakes it. In edge mode, the channel dozes whatever the line level is, and any change of the line after doze entry wakes it. The receive input first passes through a synchroniser. All level and edge decisions use the synchronised value, so a pin change reaches the state decision on the third rising clock edge after it.

All pins are plain control and status signals. No data passes through the block, so there is no handshake and no back-pressure.

Top module: `uart_doze_ctrl`

## Requirements
- R1: After reset, `doze`, `wake_evt`, `sw_rst_bit` and `chan_rst` are all 0, and the synchronised receive value starts at 1 (line idle).
- R2: The channel enters doze only on a clock edge where `doze_req` and `chan_idle` are 1 and `host_wr` and `irq_pend` are 0. `doze` rises in the cycle after that edge.
- R3: When `edge_mode` = 0, the channel does not enter doze while the synchronised receive value is 0. A change on `rx_pin` reaches the decision on the third clock edge after it.
- R4: When `edge_mode` = 0, a dozing channel wakes on the third clock edge after `rx_pin` goes low.
- R5: When `edge_mode` = 1, the channel enters doze whatever the level of the receive line.
- R6: When `edge_mode` = 1, a dozing channel wakes when the synchronised receive value differs from its value at doze entry. Both rising and falling changes wake it, on the third clock edge after the pin change.
- R7: A dozing channel wakes on the next clock edge when `host_wr` or `irq_pend` is 1.
- R8: `wake_evt` is 1 for exactly the one cycle after each doze-to-awake transition, and 0 at all other times.
- R9: A 1 on `sw_rst_wr` at a clock edge sets `sw_rst_bit` and `chan_rst` for exactly 4 cycles (RST_CYCLES). Both then return to 0 with no further action.
- R10: A `sw_rst_wr` strobe that arrives while a software reset is still running is ignored: it neither extends nor restarts the reset.
- R11: While a software reset runs, and on the edge of the strobe itself, the channel is held awake and the receive line has no effect. A dozing channel wakes, and a doze entry falling on the strobe edge does not happen.
- R12: Dropping `doze_req` wakes a dozing channel on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| doze_req | input | 1 | Host permits doze |
| chan_idle | input | 1 | Channel FIFOs empty and no interrupt outstanding |
| host_wr | input | 1 | Host register write this cycle |
| irq_pend | input | 1 | An interrupt source is pending |
| rx_pin | input | 1 | Asynchronous serial receive input |
| edge_mode | input | 1 | 0 = level wake policy, 1 = edge wake policy |
| sw_rst_wr | input | 1 | Host writes 1 to the software-reset bit |
| doze | output | 1 | Channel is dozing; gates the channel clock |
| wake_evt | output | 1 | One-cycle pulse on each return to awake |
| sw_rst_bit | output | 1 | Software-reset bit readback, clears itself |
| chan_rst | output | 1 | Reset to the channel while the software reset runs |

## Verification
The collision that matters most is a software-reset strobe landing on the same edge as a complete set of doze-entry conditions. The bench raises `sw_rst_wr`, `doze_req` and `chan_idle` on one falling edge. Reset must win: `doze` stays 0 through the whole reset window and rises only on the edge after the window closes. A second collision is a strobe arriving while the channel already dozes. There the strobe must wake the channel with a single `wake_evt` pulse. The bench also checks that the channel does not doze again until `chan_rst` has fallen.

// File: rtl/uart_doze_pkg.sv
package uart_doze_pkg;

  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } doze_state_e;

endpackage

// File: rtl/udz_rx_sync.sv
module udz_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  generate
    if (STAGES == 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= {STAGES{RST_VAL}};
        else        q <= {q[STAGES-2:0], din};
      end
      assign dout = q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/udz_rst_seq.sv
module udz_rst_seq #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst_wr,
  output logic busy
);

  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt;

  // Strobe only loads when idle; a strobe during a running reset is dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt == '0) begin
      if (sw_rst_wr) cnt <= CW'(RST_CYCLES);
    end else begin
      cnt <= cnt - CW'(1);
    end
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/udz_wake_eval.sv
module udz_wake_eval (
  input  logic clk,
  input  logic rst_n,
  input  logic asleep,
  input  logic edge_mode,
  input  logic rx_s,
  input  logic doze_req,
  input  logic chan_idle,
  input  logic host_wr,
  input  logic irq_pend,
  input  logic rst_hold,
  output logic may_enter,
  output logic must_wake
);

  // Reference follows the line while awake, so it freezes at the entry value.
  logic rx_ref;
  logic rx_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_ref <= 1'b1;
    else if (!asleep) rx_ref <= rx_s;
  end

  always_comb begin
    if (edge_mode) rx_wake = (rx_s != rx_ref);
    else           rx_wake = ~rx_s;
  end

  assign may_enter = doze_req & chan_idle & ~host_wr & ~irq_pend & ~rst_hold
                   & (edge_mode | rx_s);

  assign must_wake = rst_hold | host_wr | irq_pend | ~doze_req | rx_wake;

endmodule

// File: rtl/udz_fsm.sv
module udz_fsm
  import uart_doze_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic may_enter,
  input  logic must_wake,
  output logic asleep,
  output logic wake_evt
);

  doze_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_AWAKE;
      wake_evt <= 1'b0;
    end else begin
      wake_evt <= 1'b0;
      case (state)
        ST_AWAKE: begin
          if (may_enter) state <= ST_ASLEEP;
        end
        ST_ASLEEP: begin
          if (must_wake) begin
            state    <= ST_AWAKE;
            wake_evt <= 1'b1;
          end
        end
        default: state <= ST_AWAKE;
      endcase
    end
  end

  assign asleep = (state == ST_ASLEEP);

endmodule

// File: rtl/uart_doze_ctrl.sv
module uart_doze_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYCLES  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic doze_req,
  input  logic chan_idle,
  input  logic host_wr,
  input  logic irq_pend,
  input  logic rx_pin,
  input  logic edge_mode,
  input  logic sw_rst_wr,
  output logic doze,
  output logic wake_evt,
  output logic sw_rst_bit,
  output logic chan_rst
);

  logic rx_s;
  logic rst_busy;
  logic rst_hold;
  logic may_enter;
  logic must_wake;
  logic asleep;

  udz_rx_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rx_pin),
    .dout  (rx_s)
  );

  udz_rst_seq #(
    .RST_CYCLES (RST_CYCLES)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_rst_wr (sw_rst_wr),
    .busy      (rst_busy)
  );

  // The strobe edge already counts as reset for the doze decision.
  assign rst_hold = rst_busy | sw_rst_wr;

  udz_wake_eval u_eval (
    .clk       (clk),
    .rst_n     (rst_n),
    .asleep    (asleep),
    .edge_mode (edge_mode),
    .rx_s      (rx_s),
    .doze_req  (doze_req),
    .chan_idle (chan_idle),
    .host_wr   (host_wr),
    .irq_pend  (irq_pend),
    .rst_hold  (rst_hold),
    .may_enter (may_enter),
    .must_wake (must_wake)
  );

  udz_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .may_enter (may_enter),
    .must_wake (must_wake),
    .asleep    (asleep),
    .wake_evt  (wake_evt)
  );

  assign doze       = asleep;
  assign sw_rst_bit = rst_busy;
  assign chan_rst   = rst_busy;

endmodule

// File: rtl/uart_doze_chk.sv
module uart_doze_chk #(
  parameter int RST_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic doze_req,
  input logic chan_idle,
  input logic host_wr,
  input logic irq_pend,
  input logic edge_mode,
  input logic rx_s,
  input logic doze,
  input logic wake_evt,
  input logic sw_rst_bit,
  input logic chan_rst
);

  localparam int HW = $clog2(RST_CYCLES + 2) + 1;

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_cnt <= '0;
    else if (sw_rst_bit) hi_cnt <= hi_cnt + HW'(1);
    else                 hi_cnt <= '0;
  end

  // R2
  entry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doze) |-> $past(doze_req && chan_idle && !host_wr && !irq_pend));

  // R3
  level_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(doze) && !$past(edge_mode)) |-> $past(rx_s));

  // R7
  host_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doze && (host_wr || irq_pend)) |=> !doze);

  // R8
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> (!doze && $past(doze)));

  // R8
  wake_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(doze) |-> wake_evt);

  // R9
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_rst_bit) |-> (hi_cnt == HW'(RST_CYCLES)));

  // R10
  rst_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= HW'(RST_CYCLES));

  // R11
  rst_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |-> !doze);

endmodule

bind uart_doze_ctrl uart_doze_chk #(.RST_CYCLES(RST_CYCLES)) u_doze_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .doze_req   (doze_req),
  .chan_idle  (chan_idle),
  .host_wr    (host_wr),
  .irq_pend   (irq_pend),
  .edge_mode  (edge_mode),
  .rx_s       (rx_s),
  .doze       (doze),
  .wake_evt   (wake_evt),
  .sw_rst_bit (sw_rst_bit),
  .chan_rst   (chan_rst)
);

// File: tb/tb_uart_doze_ctrl.sv
`timescale 1ns/100ps
module tb_uart_doze_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic doze_req = 1'b0, chan_idle = 1'b0, host_wr = 1'b0, irq_pend = 1'b0;
  logic rx_pin = 1'b1, edge_mode = 1'b0, sw_rst_wr = 1'b0;
  logic doze, wake_evt, sw_rst_bit, chan_rst;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_doze_ctrl dut (
    .clk(clk), .rst_n(rst_n), .doze_req(doze_req), .chan_idle(chan_idle),
    .host_wr(host_wr), .irq_pend(irq_pend), .rx_pin(rx_pin),
    .edge_mode(edge_mode), .sw_rst_wr(sw_rst_wr), .doze(doze),
    .wake_evt(wake_evt), .sw_rst_bit(sw_rst_bit), .chan_rst(chan_rst)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    check("R1", "doze", doze, 1'b0);
    check("R1", "wake_evt", wake_evt, 1'b0);
    check("R1", "sw_rst_bit", sw_rst_bit, 1'b0);
    check("R1", "chan_rst", chan_rst, 1'b0);
  endtask

  task automatic t_entry_gate();
    doze_req = 1'b1; chan_idle = 1'b0;
    step(3); check("R2", "no doze without idle", doze, 1'b0);
    chan_idle = 1'b1; host_wr = 1'b1;
    step(1); check("R2", "no doze with host write", doze, 1'b0);
    host_wr = 1'b0;
    step(1); check("R2", "doze entered", doze, 1'b1);
    check("R8", "no pulse on entry", wake_evt, 1'b0);
    doze_req = 1'b0;
    step(1); check("R12", "req drop wakes", doze, 1'b0);
    check("R8", "wake pulse", wake_evt, 1'b1);
    step(1); check("R8", "pulse one cycle", wake_evt, 1'b0);
    chan_idle = 1'b0;
  endtask

  task automatic t_level();
    rx_pin = 1'b0; step(3);
    doze_req = 1'b1; chan_idle = 1'b1;
    step(4); check("R3", "low line blocks doze", doze, 1'b0);
    rx_pin = 1'b1;
    step(2); check("R3", "sync in flight", doze, 1'b0);
    step(1); check("R3", "doze after line high", doze, 1'b1);
    rx_pin = 1'b0;
    step(2); check("R4", "still dozing", doze, 1'b1);
    check("R4", "no pulse yet", wake_evt, 1'b0);
    step(1); check("R4", "low line wakes", doze, 1'b0);
    check("R8", "level wake pulse", wake_evt, 1'b1);
    step(1); check("R3", "stays awake while low", doze, 1'b0);
    doze_req = 1'b0; chan_idle = 1'b0; rx_pin = 1'b1;
    step(3);
  endtask

  task automatic t_edge();
    edge_mode = 1'b1; rx_pin = 1'b0; step(3);
    doze_req = 1'b1; chan_idle = 1'b1;
    step(1); check("R5", "doze with low line", doze, 1'b1);
    step(3); check("R5", "stays dozing", doze, 1'b1);
    rx_pin = 1'b1;
    step(2); check("R6", "rise not yet seen", doze, 1'b1);
    step(1); check("R6", "rise wakes", doze, 1'b0);
    check("R8", "edge wake pulse", wake_evt, 1'b1);
    step(1); check("R5", "re-entry with high line", doze, 1'b1);
    rx_pin = 1'b0;
    step(3); check("R6", "fall wakes", doze, 1'b0);
    doze_req = 1'b0;
    step(1);
    rx_pin = 1'b1; chan_idle = 1'b0;
    step(3);
    edge_mode = 1'b0;
  endtask

  task automatic t_host_irq();
    doze_req = 1'b1; chan_idle = 1'b1;
    step(1); check("R2", "doze", doze, 1'b1);
    host_wr = 1'b1;
    step(1); check("R7", "host write wakes", doze, 1'b0);
    check("R8", "host wake pulse", wake_evt, 1'b1);
    host_wr = 1'b0;
    step(1); check("R7", "re-entry", doze, 1'b1);
    irq_pend = 1'b1;
    step(1); check("R7", "irq wakes", doze, 1'b0);
    step(2); check("R7", "irq holds awake", doze, 1'b0);
    irq_pend = 1'b0;
    step(1); check("R7", "doze after irq clears", doze, 1'b1);
    doze_req = 1'b0; chan_idle = 1'b0;
    step(2);
  endtask

  task automatic t_swrst();
    sw_rst_wr = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      step(1);
      sw_rst_wr = (i == 2);
      check((i == 3) ? "R10" : "R9", "sw_rst_bit", sw_rst_bit, (i <= 4));
      check("R9", "chan_rst", chan_rst, (i <= 4));
    end
    step(2);
  endtask

  task automatic t_swrst_asleep();
    doze_req = 1'b1; chan_idle = 1'b1;
    step(1); check("R11", "doze before reset", doze, 1'b1);
    sw_rst_wr = 1'b1; edge_mode = 1'b1;
    step(1); sw_rst_wr = 1'b0;
    check("R11", "reset wakes", doze, 1'b0);
    check("R8", "reset wake pulse", wake_evt, 1'b1);
    rx_pin = 1'b0;
    for (int i = 2; i <= 5; i++) begin
      step(1);
      check("R11", "held awake in reset", doze, 1'b0);
      check("R8", "no extra pulse", wake_evt, 1'b0);
    end
    step(1); check("R11", "doze after reset", doze, 1'b1);
    doze_req = 1'b0; chan_idle = 1'b0; rx_pin = 1'b1; edge_mode = 1'b0;
    step(4);
  endtask

  task automatic t_collide();
    sw_rst_wr = 1'b1; doze_req = 1'b1; chan_idle = 1'b1;
    step(1); sw_rst_wr = 1'b0;
    check("R11", "strobe beats entry", doze, 1'b0);
    check("R11", "reset running", chan_rst, 1'b1);
    step(3); check("R11", "awake at cycle 4", doze, 1'b0);
    step(1); check("R9", "reset cleared", chan_rst, 1'b0);
    check("R11", "awake at cycle 5", doze, 1'b0);
    step(1); check("R11", "doze after window", doze, 1'b1);
    doze_req = 1'b0; chan_idle = 1'b0;
    step(2);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_entry_gate();
    t_level();
    t_edge();
    t_host_irq();
    t_swrst();
    t_swrst_asleep();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule